// File: doc/BRIEF.md
# Endpoint Interrupt Message Request Controller

This block sits between the interrupt sources of an endpoint application and the transmit side of a PCI Express transaction layer. It turns interrupt activity into message requests toward that transmit side. Each request is held until the transmit side returns an acknowledge. The transmit side is modelled as a plain request/acknowledge pair. Message formatting, configuration space and link behaviour are left to other blocks.

In legacy mode the block follows one level-sensitive status input. When the level goes high it requests an Assert_INTA message, and when it goes low it requests a Deassert_INTA message. In MSI mode it takes three kinds of event: system error, hot-plug or power-management, and application vectors. It turns each one into an MSI number, which depends on how many vectors the host granted and on a static option that can give the two system classes one shared top vector. It also picks the traffic class for the message.

Top module: `irq_msg_ctrl`

## Requirements
- R1: While reset is low and just after it is released, `tx_req_o` and `int_ack_o` are 0.
- R2: In legacy mode (`msi_mode_i`=0), a rise of `leg_sts_i` raises `tx_req_o` one edge later with `tx_kind_o`=0 (assert), `tx_num_o`=0 and `tx_tc_o`=0. `int_ack_o` is high in the cycle in which `tx_ack_i` meets the open request.
- R3: In legacy mode, a fall of `leg_sts_i` produces exactly one request with `tx_kind_o`=1 (deassert). It is acknowledged in the same way as the assert request.
- R4: If `leg_sts_i` drops again before the assert request is acknowledged, a deassert request still follows that acknowledge. Legacy requests therefore always alternate, starting with assert.
- R5: In MSI mode (`tx_kind_o`=2) with `alloc_log2_i`=5 (32 vectors) and `share_top_i`=0, system error uses number 31 and hot-plug/power uses number 30. An application vector uses its own number, and any value above 29 is clamped to 29.
- R6: With `alloc_log2_i`=2 (4 vectors) and `share_top_i`=0, system error uses 3 and hot-plug/power uses 2. Application vectors are clamped to 1.
- R7: With `share_top_i`=1, system error and hot-plug/power both use the top vector (3 for 4 vectors). Application vectors are clamped to one below the top (2 for 4 vectors).
- R8: System error and hot-plug/power messages carry traffic class 0. An application message carries the `app_tc_i` value that was captured with its request.
- R9: Only one request is open at a time. While `tx_req_o` is high and `tx_ack_i` is low, all request fields stay unchanged. `tx_req_o` drops on the edge at which `tx_ack_i` is seen, and the next request cannot appear before the edge after that.
- R10: Events that arrive while a request is open stay pending. They are issued one at a time, system error first, then hot-plug/power, then application.
- R11: In legacy mode the MSI event inputs are ignored and produce no request. In MSI mode `leg_sts_i` is ignored and produces no request.
- R12: With 2 vectors, system error and hot-plug/power use 1 and application uses 0. With 1 vector, every class uses 0. `alloc_log2_i` values above 5 act as 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msi_mode_i | input | 1 | 1 selects MSI mode, 0 selects legacy mode (static) |
| alloc_log2_i | input | 3 | Log2 of the number of vectors the host granted (static) |
| share_top_i | input | 1 | System error and hot-plug/power share the top vector (static) |
| leg_sts_i | input | 1 | Legacy interrupt level from the application |
| sys_err_i | input | 1 | System error event pulse |
| hp_pm_i | input | 1 | Hot-plug or power-management event pulse |
| app_req_i | input | 1 | Application MSI event pulse |
| app_vec_i | input | 5 | Application vector number, captured with `app_req_i` |
| app_tc_i | input | 3 | Application traffic class, captured with `app_req_i` |
| tx_req_o | output | 1 | Message request to the transmit side |
| tx_kind_o | output | 2 | 0 assert, 1 deassert, 2 MSI |
| tx_num_o | output | 5 | MSI number (0 for legacy messages) |
| tx_tc_o | output | 3 | Traffic class of the message |
| tx_ack_i | input | 1 | Transmit side reports the message as sent |
| int_ack_o | output | 1 | Acknowledge back to the sources for the open request |

## Verification
An input change sampled at clock edge t shows up on `tx_req_o` and its fields after edge t. This includes an event that arrives in the same cycle as an idle slot. An acknowledge seen at edge t clears the request after t, and a pending event can then be issued no earlier than edge t+1. `int_ack_o` is combinational and follows `tx_ack_i` within the same cycle. The bench drives inputs just after each rising edge. It steps a behavioural model on the rising edge and compares every output with that model at the falling edge. A variable-delay acknowledge responder keeps requests open for several cycles, so that the hold, pending and priority rules are checked in the cycles where they apply.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  localparam int unsigned VEC_W = 5;
  localparam int unsigned TC_W  = 3;
  localparam int unsigned LOG_W = 3;

  typedef enum logic [1:0] {
    KIND_ASSERT   = 2'd0,
    KIND_DEASSERT = 2'd1,
    KIND_MSI      = 2'd2
  } msg_kind_e;
endpackage

// File: rtl/irq_vec_map.sv
module irq_vec_map #(
  parameter int unsigned VEC_W = 5,
  parameter int unsigned LOG_W = 3
) (
  input  logic [LOG_W-1:0] log2_i,
  input  logic             share_i,
  input  logic [VEC_W-1:0] app_vec_i,
  output logic [VEC_W-1:0] se_num_o,
  output logic [VEC_W-1:0] hp_num_o,
  output logic [VEC_W-1:0] app_num_o
);
  localparam int unsigned NW = VEC_W + 1;

  logic [LOG_W-1:0] eff_log2;
  logic [NW-1:0]    n_vec, top_w, hp_w, amax_w, vec_w;

  always_comb begin
    eff_log2 = (32'(log2_i) > VEC_W) ? LOG_W'(VEC_W) : log2_i;
    n_vec    = NW'(1) << eff_log2;
    top_w    = n_vec - NW'(1);
    if (!share_i && n_vec >= NW'(4)) begin
      hp_w   = n_vec - NW'(2);
      amax_w = n_vec - NW'(3);
    end else begin
      hp_w   = top_w;
      amax_w = (n_vec >= NW'(2)) ? n_vec - NW'(2) : '0;
    end
    vec_w     = {1'b0, app_vec_i};
    se_num_o  = top_w[VEC_W-1:0];
    hp_num_o  = hp_w[VEC_W-1:0];
    app_num_o = (vec_w > amax_w) ? amax_w[VEC_W-1:0] : app_vec_i;
  end

  // R12: class ordering holds for every allocation
  always_comb begin
    a_order_r12: assert (app_num_o <= hp_num_o && hp_num_o <= se_num_o)
      else $error("vector class order broken");
  end
endmodule

// File: rtl/irq_msi_pend.sv
module irq_msi_pend #(
  parameter int unsigned VEC_W = 5,
  parameter int unsigned TC_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             se_i,
  input  logic             hp_i,
  input  logic             app_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [TC_W-1:0]  tc_i,
  input  logic             take_se_i,
  input  logic             take_hp_i,
  input  logic             take_app_i,
  output logic             se_c_o,
  output logic             hp_c_o,
  output logic             app_c_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [TC_W-1:0]  tc_o
);
  logic             se_q, hp_q, app_q;
  logic [VEC_W-1:0] vec_q;
  logic [TC_W-1:0]  tc_q;
  logic             app_new;

  assign app_new = en_i & app_i;
  // candidates include same-cycle arrivals
  assign se_c_o  = se_q  | (en_i & se_i);
  assign hp_c_o  = hp_q  | (en_i & hp_i);
  assign app_c_o = app_q | app_new;
  assign vec_o   = app_new ? vec_i : vec_q;
  assign tc_o    = app_new ? tc_i  : tc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      se_q  <= 1'b0;
      hp_q  <= 1'b0;
      app_q <= 1'b0;
      vec_q <= '0;
      tc_q  <= '0;
    end else begin
      se_q  <= se_c_o  & ~take_se_i;
      hp_q  <= hp_c_o  & ~take_hp_i;
      app_q <= app_c_o & ~take_app_i;
      if (app_new) begin
        vec_q <= vec_i;
        tc_q  <= tc_i;
      end
    end
  end

  // R10: a granted class is not pending afterwards unless it re-arrives
  p_take_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_se_i && !(en_i && se_i) |=> !se_q || (en_i && $past(se_i)))
    else $error("system error pending after grant");
endmodule

// File: rtl/irq_leg_track.sv
module irq_leg_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sts_i,
  input  logic take_i,
  output logic want_o,
  output logic level_o
);
  logic line_q;  // level last sent to the host

  assign want_o  = en_i & (sts_i ^ line_q);
  assign level_o = sts_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     line_q <= 1'b0;
    else if (take_i) line_q <= sts_i;
  end

  // R4: a grant always flips the line state
  p_flip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> line_q != $past(line_q))
    else $error("legacy grant without level change");
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
  import irq_msg_pkg::*;
#(
  parameter int unsigned P_VEC_W = VEC_W,
  parameter int unsigned P_TC_W  = TC_W,
  parameter int unsigned P_LOG_W = LOG_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               msi_mode_i,
  input  logic [P_LOG_W-1:0] alloc_log2_i,
  input  logic               share_top_i,
  input  logic               leg_sts_i,
  input  logic               sys_err_i,
  input  logic               hp_pm_i,
  input  logic               app_req_i,
  input  logic [P_VEC_W-1:0] app_vec_i,
  input  logic [P_TC_W-1:0]  app_tc_i,
  output logic               tx_req_o,
  output logic [1:0]         tx_kind_o,
  output logic [P_VEC_W-1:0] tx_num_o,
  output logic [P_TC_W-1:0]  tx_tc_o,
  input  logic               tx_ack_i,
  output logic               int_ack_o
);
  logic               se_c, hp_c, app_c, leg_c, leg_level;
  logic [P_VEC_W-1:0] app_vec_c, se_num, hp_num, app_num;
  logic [P_TC_W-1:0]  app_tc_c;
  logic               take_se, take_hp, take_app, take_leg, issue;

  logic               req_q;
  msg_kind_e          kind_q;
  logic [P_VEC_W-1:0] num_q;
  logic [P_TC_W-1:0]  tc_q;
  logic               last_assert_q;

  irq_msi_pend #(.VEC_W(P_VEC_W), .TC_W(P_TC_W)) u_pend (
    .clk_i, .rst_ni,
    .en_i      (msi_mode_i),
    .se_i      (sys_err_i),
    .hp_i      (hp_pm_i),
    .app_i     (app_req_i),
    .vec_i     (app_vec_i),
    .tc_i      (app_tc_i),
    .take_se_i (take_se),
    .take_hp_i (take_hp),
    .take_app_i(take_app),
    .se_c_o    (se_c),
    .hp_c_o    (hp_c),
    .app_c_o   (app_c),
    .vec_o     (app_vec_c),
    .tc_o      (app_tc_c)
  );

  irq_leg_track u_leg (
    .clk_i, .rst_ni,
    .en_i   (~msi_mode_i),
    .sts_i  (leg_sts_i),
    .take_i (take_leg),
    .want_o (leg_c),
    .level_o(leg_level)
  );

  irq_vec_map #(.VEC_W(P_VEC_W), .LOG_W(P_LOG_W)) u_map (
    .log2_i   (alloc_log2_i),
    .share_i  (share_top_i),
    .app_vec_i(app_vec_c),
    .se_num_o (se_num),
    .hp_num_o (hp_num),
    .app_num_o(app_num)
  );

  // fixed priority grant, one request at a time
  always_comb begin
    take_se  = 1'b0;
    take_hp  = 1'b0;
    take_app = 1'b0;
    take_leg = 1'b0;
    if (!req_q) begin
      if (msi_mode_i) begin
        if (se_c)       take_se  = 1'b1;
        else if (hp_c)  take_hp  = 1'b1;
        else if (app_c) take_app = 1'b1;
      end else begin
        take_leg = leg_c;
      end
    end
    issue = take_se | take_hp | take_app | take_leg;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      kind_q <= KIND_ASSERT;
      num_q  <= '0;
      tc_q   <= '0;
    end else if (req_q) begin
      if (tx_ack_i) req_q <= 1'b0;
    end else if (issue) begin
      req_q <= 1'b1;
      if (take_leg) begin
        kind_q <= leg_level ? KIND_ASSERT : KIND_DEASSERT;
        num_q  <= '0;
        tc_q   <= '0;
      end else begin
        kind_q <= KIND_MSI;
        num_q  <= take_se ? se_num : (take_hp ? hp_num : app_num);
        tc_q   <= take_app ? app_tc_c : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       last_assert_q <= 1'b0;
    else if (take_leg) last_assert_q <= leg_level;
  end

  assign tx_req_o  = req_q;
  assign tx_kind_o = kind_q;
  assign tx_num_o  = num_q;
  assign tx_tc_o   = tc_q;
  assign int_ack_o = req_q & tx_ack_i;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o && !tx_ack_i |=> tx_req_o && $stable(tx_kind_o) && $stable(tx_num_o) && $stable(tx_tc_o))
    else $error("request changed before acknowledge");

  p_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o && tx_ack_i |=> !tx_req_o)
    else $error("request not released after acknowledge");

  p_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_ack_o |=> !tx_req_o)
    else $error("ack to sources without release");

  p_tc0_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_req_o && msi_mode_i && (se_c || hp_c) |=> tx_tc_o == '0)
    else $error("system class message with nonzero class");

  p_prio_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_req_o && msi_mode_i && se_c |=> tx_num_o == $past(se_num))
    else $error("system error not granted first");

  p_range_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o && tx_kind_o == KIND_MSI |-> tx_num_o <= se_num)
    else $error("MSI number above allocation");

  p_alt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_req_o) && tx_kind_o != KIND_MSI |-> (tx_kind_o == KIND_ASSERT) != $past(last_assert_q))
    else $error("legacy messages out of order");
endmodule

// File: tb/irq_msg_ctrl_bench.sv
`timescale 1ns/1ps
module irq_msg_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       msi_mode = 1'b0, share_top = 1'b0, leg_sts = 1'b0;
  logic [2:0] alloc_log2 = 3'd5;
  logic       sys_err = 1'b0, hp_pm = 1'b0, app_req = 1'b0;
  logic [4:0] app_vec = '0;
  logic [2:0] app_tc = '0;
  logic       tx_req, tx_ack = 1'b0, int_ack;
  logic [1:0] tx_kind;
  logic [4:0] tx_num;
  logic [2:0] tx_tc;

  int total = 0, bad = 0, issued = 0, ack_dly = 0, wcnt = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  irq_msg_ctrl u_irq_msg_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .msi_mode_i(msi_mode), .alloc_log2_i(alloc_log2),
    .share_top_i(share_top), .leg_sts_i(leg_sts), .sys_err_i(sys_err), .hp_pm_i(hp_pm),
    .app_req_i(app_req), .app_vec_i(app_vec), .app_tc_i(app_tc), .tx_req_o(tx_req),
    .tx_kind_o(tx_kind), .tx_num_o(tx_num), .tx_tc_o(tx_tc), .tx_ack_i(tx_ack),
    .int_ack_o(int_ack)
  );

  // reference numbering from the requirements
  function automatic int ref_num(int cls, int k, bit shr, int vec);
    int n, amax, hp;
    n = 1 << ((k > 5) ? 5 : k);
    if (!shr && n >= 4) begin hp = n - 2; amax = n - 3; end
    else begin hp = n - 1; amax = (n >= 2) ? n - 2 : 0; end
    if (cls == 0) return n - 1;
    if (cls == 1) return hp;
    return (vec > amax) ? amax : vec;
  endfunction

  // behavioural model
  bit m_req, m_line, m_se, m_hp, m_app;
  int m_kind, m_num, m_tc, m_vec, m_atc;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_req = 0; m_line = 0; m_se = 0; m_hp = 0; m_app = 0;
      m_kind = 0; m_num = 0; m_tc = 0; m_vec = 0; m_atc = 0;
    end else begin
      bit se_c, hp_c, ap_c;
      int vec_c, tc_c;
      se_c  = m_se  || (msi_mode && sys_err);
      hp_c  = m_hp  || (msi_mode && hp_pm);
      ap_c  = m_app || (msi_mode && app_req);
      vec_c = (msi_mode && app_req) ? int'(app_vec) : m_vec;
      tc_c  = (msi_mode && app_req) ? int'(app_tc)  : m_atc;
      if (msi_mode && app_req) begin m_vec = app_vec; m_atc = app_tc; end
      m_se = se_c; m_hp = hp_c; m_app = ap_c;
      if (m_req) begin
        if (tx_ack) m_req = 0;
      end else if (msi_mode) begin
        if (se_c) begin
          m_req = 1; m_kind = 2; m_tc = 0; m_se = 0;
          m_num = ref_num(0, alloc_log2, share_top, 0);
        end else if (hp_c) begin
          m_req = 1; m_kind = 2; m_tc = 0; m_hp = 0;
          m_num = ref_num(1, alloc_log2, share_top, 0);
        end else if (ap_c) begin
          m_req = 1; m_kind = 2; m_tc = tc_c; m_app = 0;
          m_num = ref_num(2, alloc_log2, share_top, vec_c);
        end
      end else if (leg_sts != m_line) begin
        m_req = 1; m_kind = leg_sts ? 0 : 1; m_num = 0; m_tc = 0; m_line = leg_sts;
      end
    end
  end

  // per-cycle comparison away from the active edge
  bit prev_req = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      bit ok;
      total++;
      ok = (tx_req == m_req) && (int_ack == (m_req && tx_ack));
      if (m_req) ok = ok && (int'(tx_kind) == m_kind) && (int'(tx_num) == m_num) && (int'(tx_tc) == m_tc);
      if (!ok) begin
        bad++;
        $display("FAIL %s t=%0t req=%0b kind=%0d num=%0d tc=%0d ack=%0b exp req=%0b kind=%0d num=%0d tc=%0d ack=%0b",
                 tag, $time, tx_req, tx_kind, tx_num, tx_tc, int_ack,
                 m_req, m_kind, m_num, m_tc, m_req && tx_ack);
      end
      if (tx_req && !prev_req) issued++;
    end
    prev_req = tx_req;
  end

  // acknowledge responder with programmable delay
  always @(posedge clk) begin
    #1;
    if (tx_req && !tx_ack) begin
      if (wcnt >= ack_dly) begin tx_ack = 1'b1; wcnt = 0; end
      else wcnt++;
    end else tx_ack = 1'b0;
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(bit msi, int k, bit shr);
    rst_n = 1'b0; msi_mode = msi; alloc_log2 = 3'(k); share_top = shr;
    leg_sts = 1'b0; sys_err = 1'b0; hp_pm = 1'b0; app_req = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    total++;
    if (tx_req !== 1'b0 || int_ack !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset req=%0b ack=%0b exp 0 0", tx_req, int_ack);
    end
    rst_n = 1'b1;
    issued = 0;
    step(1);
  endtask

  task automatic expect_issued(int exp, string t);
    total++;
    if (issued != exp) begin
      bad++;
      $display("FAIL %s issued=%0d exp=%0d", t, issued, exp);
    end
    issued = 0;
  endtask

  task automatic pulse_app(int vec, int tc);
    app_req = 1'b1; app_vec = 5'(vec); app_tc = 3'(tc);
    step(1);
    app_req = 1'b0;
  endtask

  task automatic pulse_sys(bit se, bit hp);
    sys_err = se; hp_pm = hp;
    step(1);
    sys_err = 1'b0; hp_pm = 1'b0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 R2 R3
    tag = "R2"; ack_dly = 2;
    do_reset(1'b0, 5, 1'b0);
    leg_sts = 1'b1; step(8);
    tag = "R3";
    leg_sts = 1'b0; step(8);
    expect_issued(2, "R3");

    // R4: level falls back before assert acknowledge
    tag = "R4"; ack_dly = 5;
    leg_sts = 1'b1; step(1); leg_sts = 1'b0; step(20);
    expect_issued(2, "R4");

    // R11: MSI events ignored in legacy mode
    tag = "R11";
    pulse_sys(1'b1, 1'b1); pulse_app(3, 2); step(6);
    expect_issued(0, "R11");
    do_reset(1'b1, 5, 1'b0);
    leg_sts = 1'b1; step(4); leg_sts = 1'b0; step(4);
    expect_issued(0, "R11");

    // R5 R8: 32 vectors
    tag = "R5"; ack_dly = 1;
    pulse_sys(1'b1, 1'b0); step(5);
    pulse_sys(1'b0, 1'b1); step(5);
    tag = "R8";
    pulse_app(10, 5); step(5);
    tag = "R5";
    pulse_app(31, 7); step(5);
    pulse_app(29, 1); step(5);
    expect_issued(5, "R5");

    // R10 R9: pending and priority behind a slow acknowledge
    tag = "R10"; ack_dly = 6;
    pulse_app(4, 3);
    pulse_app(7, 6); pulse_sys(1'b1, 1'b1);
    step(40);
    expect_issued(4, "R10");
    tag = "R9"; ack_dly = 0;
    pulse_sys(1'b1, 1'b0); pulse_sys(1'b1, 1'b0); pulse_app(2, 4); step(10);
    expect_issued(3, "R9");

    // R6: 4 vectors, separate classes
    tag = "R6"; ack_dly = 1;
    do_reset(1'b1, 2, 1'b0);
    pulse_sys(1'b1, 1'b1); step(8);
    pulse_app(0, 1); step(4); pulse_app(1, 2); step(4); pulse_app(9, 3); step(4);
    expect_issued(5, "R6");

    // R7: shared top vector
    tag = "R7";
    do_reset(1'b1, 2, 1'b1);
    pulse_sys(1'b1, 1'b1); step(8);
    pulse_app(2, 1); step(4); pulse_app(3, 2); step(4);
    expect_issued(4, "R7");

    // R12: small and oversized allocations
    tag = "R12";
    do_reset(1'b1, 1, 1'b0);
    pulse_sys(1'b1, 1'b1); step(8); pulse_app(5, 1); step(4);
    do_reset(1'b1, 0, 1'b0);
    pulse_sys(1'b1, 1'b1); step(8); pulse_app(5, 1); step(4);
    do_reset(1'b1, 7, 1'b0);
    pulse_sys(1'b1, 1'b1); step(8); pulse_app(30, 1); step(4);
    expect_issued(3, "R12");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule